// File: doc/BRIEF.md
# Pseudo-SRAM configuration and power controller

This block is the control slice of a pseudo-SRAM die that owns the configuration registers and the power state. A side-band configuration enable steers a read or a write away from the memory array and toward one of three registers. A 2-bit field of the address picks the register. The low-power register controls whether the die drops into deep power-down when chip enable is released. The bus register is a plain read/write store. A constant identification word can be read but not written. Configuration write data is taken from the low address lines.

All control inputs are sampled on the rising clock edge, and every output is registered, so a result appears one cycle after the edge that sampled the access. Array reads and writes are not served here. The block only raises a one-cycle strobe for the array datapath, and it withholds that strobe while the die is asleep.

Deep power-down is entered when chip enable rises while the low-power bit is clear. It is left only after chip enable has been held low for a parameterised number of consecutive cycles. Leaving deep power-down restores every register to its reset value.

Top module: `psram_cfg_pwr`

## Requirements
- R1: After reset the power state is standby (code 0), all strobes and cfg_drive are low, the low-power register holds 16'h0010 (bit 4 set) and the bus register holds 16'h9D4F.
- R2: With the die awake and ce_n low, a read with cfg_en high, oe_n low and we_n high sets cfg_drive and puts the selected register on cfg_dout one cycle later, with no array strobe. With cfg_en low, array_rd_en (oe_n low, we_n high) or array_wr_en (we_n low) rises one cycle later instead.
- R3: In the wide map (LARGE_MAP=1) the select field is {addr[19],addr[18]}. 00 selects the low-power register, 10 selects the bus register, and either code with addr[18]=1 selects the identification word 16'h0C5A.
- R4: A write aimed at the identification word changes no register. A later read still returns 16'h0C5A, and the other two registers keep their values.
- R5: In the narrow map (LARGE_MAP=0) only addr[19] selects: 0 is the low-power register and 1 is the bus register. addr[18] has no effect.
- R6: A configuration write occurs when the die is awake, ce_n is low, we_n is low and cfg_en is high. The new value is addr[15:0], and it can be read back from the next cycle on.
- R7: If ce_n is sampled high while active and bit 4 of the low-power register is 1, the state becomes standby on the next cycle and the registers keep their values.
- R8: If ce_n is sampled high while active and bit 4 of the low-power register is 0, the state becomes deep power-down (code 2) on the next cycle.
- R9: While in deep power-down, no access has any effect: array_rd_en, array_wr_en and cfg_drive stay low.
- R10: Deep power-down is left for standby only on the DPD_LOW_CYC-th consecutive edge that samples ce_n low. A shorter low pulse leaves the state at deep power-down.
- R11: Leaving deep power-down reloads both writable registers with their reset values.
- R12: From standby, an edge that samples ce_n low moves the state to active (code 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cfg_en | input | 1 | Routes the access to the configuration registers when high |
| addr | input | ADDR_W | Address; [19:18] select the register, [15:0] carry write data |
| pwr_state | output | 2 | 0 standby, 1 active, 2 deep power-down |
| cfg_drive | output | 1 | Register read data is being driven |
| cfg_dout | output | DATA_W | Register read data, zero when not driven |
| array_rd_en | output | 1 | One-cycle array read strobe |
| array_wr_en | output | 1 | One-cycle array write strobe |

## Verification
A wrong power state shows up within one cycle: strobes that should appear are missing, or cfg_drive rises while the die should be asleep. The exit counter is checked at its exact boundary. A pulse one cycle short must leave the die asleep, and the full-length pulse must wake it on exactly the last low edge. A register that was corrupted or not restored is exposed by the first configuration read, one cycle after it is issued. The narrow and wide select maps are told apart by sending the same address to two instances and comparing what each one returns.

// File: rtl/psc_pkg.sv
package psc_pkg;
   typedef enum logic [1:0] {
      PWR_STBY = 2'd0,
      PWR_ACT  = 2'd1,
      PWR_DPD  = 2'd2
   } pwr_e;

   typedef enum logic [1:0] {
      SEL_LP  = 2'd0,
      SEL_BUS = 2'd1,
      SEL_ID  = 2'd2
   } csel_e;
endpackage

// File: rtl/psc_decode.sv
module psc_decode
   import psc_pkg::*;
#(
   parameter bit LARGE_MAP = 1'b1
) (
   input  logic [1:0] sel_bits,
   output csel_e      sel
);
   generate
      if (LARGE_MAP) begin : g_wide
         always_comb begin
            if (sel_bits[0])      sel = SEL_ID;
            else if (sel_bits[1]) sel = SEL_BUS;
            else                  sel = SEL_LP;
         end
      end else begin : g_narrow
         logic unused_low_sel;
         assign unused_low_sel = sel_bits[0];
         always_comb sel = sel_bits[1] ? SEL_BUS : SEL_LP;
      end
   endgenerate
endmodule

// File: rtl/psc_regs.sv
module psc_regs
   import psc_pkg::*;
#(
   parameter int unsigned      DATA_W  = 16,
   parameter logic [DATA_W-1:0] LP_RST  = 16'h0010,
   parameter logic [DATA_W-1:0] BUS_RST = 16'h9D4F,
   parameter logic [DATA_W-1:0] ID_VAL  = 16'h0C5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic              wr_en,
   input  csel_e             sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] lp_q,
   output logic [DATA_W-1:0] bus_q,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_q  <= LP_RST;
         bus_q <= BUS_RST;
      end else if (reload) begin
         lp_q  <= LP_RST;
         bus_q <= BUS_RST;
      end else if (wr_en) begin
         case (sel)
            SEL_LP:  lp_q  <= wr_data;
            SEL_BUS: bus_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_LP:  rd_data = lp_q;
         SEL_BUS: rd_data = bus_q;
         default: rd_data = ID_VAL;
      endcase
   end
endmodule

// File: rtl/psc_power.sv
module psc_power
   import psc_pkg::*;
#(
   parameter int unsigned LOW_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic keep_awake,
   output pwr_e state_q,
   output logic reload,
   output logic awake
);
   localparam int unsigned CW = $clog2(LOW_CYC + 1);

   logic [CW-1:0] low_cnt;
   logic          cnt_done;
   pwr_e          state_d;

   assign cnt_done = !ce_n && (low_cnt == CW'(LOW_CYC - 1));
   assign reload   = (state_q == PWR_DPD) && cnt_done;
   assign awake    = (state_q != PWR_DPD);

   always_comb begin
      state_d = state_q;
      case (state_q)
         PWR_STBY: if (!ce_n) state_d = PWR_ACT;
         PWR_ACT:  if (ce_n)  state_d = keep_awake ? PWR_STBY : PWR_DPD;
         PWR_DPD:  if (cnt_done) state_d = PWR_STBY;
         default:  state_d = PWR_STBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWR_STBY;
         low_cnt <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == PWR_DPD && !ce_n && !cnt_done) low_cnt <= low_cnt + 1'b1;
         else                                          low_cnt <= '0;
      end
   end
endmodule

// File: rtl/psram_cfg_pwr.sv
module psram_cfg_pwr
   import psc_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 22,
   parameter int unsigned       DATA_W      = 16,
   parameter int unsigned       SEL_LSB     = 18,
   parameter bit                LARGE_MAP   = 1'b1,
   parameter int unsigned       DPD_LOW_CYC = 8,
   parameter int unsigned       LP_BIT      = 4,
   parameter logic [DATA_W-1:0] LP_RST      = 16'h0010,
   parameter logic [DATA_W-1:0] BUS_RST     = 16'h9D4F,
   parameter logic [DATA_W-1:0] ID_VAL      = 16'h0C5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              cfg_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        pwr_state,
   output logic              cfg_drive,
   output logic [DATA_W-1:0] cfg_dout,
   output logic              array_rd_en,
   output logic              array_wr_en
);
   generate
      if (SEL_LSB <= DATA_W)   begin : g_bad_sel  $error("select field overlaps write data"); end
      if (ADDR_W <= SEL_LSB+2) begin : g_bad_addr $error("address too narrow for select field"); end
      if (LP_BIT >= DATA_W)    begin : g_bad_bit  $error("low-power bit outside register"); end
      if (DPD_LOW_CYC < 2)     begin : g_bad_cyc  $error("wake window must be at least 2 cycles"); end
   endgenerate

   csel_e             sel;
   pwr_e              state_q;
   logic              reload, awake;
   logic [DATA_W-1:0] lp_q, bus_q, rd_mux;
   logic              access, cfg_wr, cfg_rd, arr_wr, arr_rd;
   logic              unused_addr;

   assign unused_addr = ^{addr[ADDR_W-1:SEL_LSB+2], addr[SEL_LSB-1:DATA_W]};

   psc_decode #(.LARGE_MAP(LARGE_MAP)) u_dec (
      .sel_bits (addr[SEL_LSB+1:SEL_LSB]),
      .sel      (sel)
   );

   psc_power #(.LOW_CYC(DPD_LOW_CYC)) u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .keep_awake (lp_q[LP_BIT]),
      .state_q    (state_q),
      .reload     (reload),
      .awake      (awake)
   );

   assign access = awake && !ce_n;
   assign cfg_wr = access &&  cfg_en && !we_n;
   assign cfg_rd = access &&  cfg_en &&  we_n && !oe_n;
   assign arr_wr = access && !cfg_en && !we_n;
   assign arr_rd = access && !cfg_en &&  we_n && !oe_n;

   psc_regs #(
      .DATA_W  (DATA_W),
      .LP_RST  (LP_RST),
      .BUS_RST (BUS_RST),
      .ID_VAL  (ID_VAL)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (reload),
      .wr_en   (cfg_wr),
      .sel     (sel),
      .wr_data (addr[DATA_W-1:0]),
      .lp_q    (lp_q),
      .bus_q   (bus_q),
      .rd_data (rd_mux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_drive   <= 1'b0;
         cfg_dout    <= '0;
         array_rd_en <= 1'b0;
         array_wr_en <= 1'b0;
      end else begin
         cfg_drive   <= cfg_rd;
         cfg_dout    <= cfg_rd ? rd_mux : '0;
         array_rd_en <= arr_rd;
         array_wr_en <= arr_wr;
      end
   end

   assign pwr_state = state_q;
endmodule

// File: rtl/psram_cfg_pwr_chk.sv
module psram_cfg_pwr_chk #(
   parameter int unsigned       DATA_W      = 16,
   parameter int unsigned       LP_BIT      = 4,
   parameter int unsigned       DPD_LOW_CYC = 8,
   parameter logic [DATA_W-1:0] LP_RST      = 16'h0010,
   parameter logic [DATA_W-1:0] BUS_RST     = 16'h9D4F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic [1:0]        pwr_state,
   input logic              cfg_drive,
   input logic              array_rd_en,
   input logic              array_wr_en,
   input logic [DATA_W-1:0] lp_q,
   input logic [DATA_W-1:0] bus_q
);
   localparam int unsigned CW = $clog2(DPD_LOW_CYC + 1);
   logic [CW-1:0] low_seen;
   logic          wake_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_seen <= '0;
      else if (pwr_state == 2'd2 && !ce_n) low_seen <= low_seen + 1'b1;
      else                                 low_seen <= '0;
   end
   assign wake_ok = !ce_n && (low_seen >= CW'(DPD_LOW_CYC - 1));

   // R2
   exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_drive, array_rd_en, array_wr_en}));

   // R7
   stby_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd1 && ce_n && lp_q[LP_BIT]) |=> (pwr_state == 2'd0 && lp_q == $past(lp_q)));

   // R8
   dpd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd1 && ce_n && !lp_q[LP_BIT]) |=> (pwr_state == 2'd2));

   // R9
   dpd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2) |=> !(cfg_drive || array_rd_en || array_wr_en));

   // R10
   dpd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2 && !wake_ok) |=> (pwr_state == 2'd2));

   // R11
   wake_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && $past(pwr_state) == 2'd2) |-> (lp_q == LP_RST && bus_q == BUS_RST));

   // R12
   stby_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && !ce_n) |=> (pwr_state == 2'd1));
endmodule

bind psram_cfg_pwr psram_cfg_pwr_chk #(
   .DATA_W      (DATA_W),
   .LP_BIT      (LP_BIT),
   .DPD_LOW_CYC (DPD_LOW_CYC),
   .LP_RST      (LP_RST),
   .BUS_RST     (BUS_RST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_n        (ce_n),
   .pwr_state   (pwr_state),
   .cfg_drive   (cfg_drive),
   .array_rd_en (array_rd_en),
   .array_wr_en (array_wr_en),
   .lp_q        (lp_q),
   .bus_q       (bus_q)
);

// File: tb/tb_psram_cfg_pwr.sv
module tb_psram_cfg_pwr;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, cfg_en = 1'b0;
   logic [21:0] addr = '0;
   logic [1:0]  st_w, st_n;
   logic        drv_w, drv_n, ard_w, ard_n, awr_w, awr_n;
   logic [15:0] dout_w, dout_n;
   int          n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   psram_cfg_pwr #(.LARGE_MAP(1'b1), .DPD_LOW_CYC(N)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .cfg_en(cfg_en),
      .addr(addr), .pwr_state(st_w), .cfg_drive(drv_w), .cfg_dout(dout_w),
      .array_rd_en(ard_w), .array_wr_en(awr_w));

   psram_cfg_pwr #(.LARGE_MAP(1'b0), .DPD_LOW_CYC(N)) dut_s (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .cfg_en(cfg_en),
      .addr(addr), .pwr_state(st_n), .cfg_drive(drv_n), .cfg_dout(dout_n),
      .array_rd_en(ard_n), .array_wr_en(awr_n));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [21:0] mk(logic [1:0] s, logic [15:0] d);
      return {2'b00, s, 2'b00, d};
   endfunction

   task automatic idle();
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; cfg_en = 1'b0; addr = '0;
      @(negedge clk);
   endtask

   task automatic cfg_wr(logic [1:0] s, logic [15:0] d);
      ce_n = 1'b0; cfg_en = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = mk(s, d);
      @(negedge clk);
      we_n = 1'b1;
   endtask

   task automatic cfg_rd(logic [1:0] s);
      ce_n = 1'b0; cfg_en = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = mk(s, 16'h0);
      @(negedge clk);
      oe_n = 1'b1;
   endtask

   task automatic t_reset();
      check("R1 state", st_w, 2'd0);
      check("R1 drive", drv_w, 1'b0);
      check("R1 strobes", {ard_w, awr_w}, 2'b00);
      cfg_rd(2'b00);
      check("R1 lp default", dout_w, 16'h0010);
      check("R2 drive on read", drv_w, 1'b1);
      check("R12 standby->active", st_w, 2'd1);
      cfg_rd(2'b10);
      check("R1 bus default", dout_w, 16'h9D4F);
      cfg_rd(2'b01);
      check("R3 id via 01", dout_w, 16'h0C5A);
      cfg_rd(2'b11);
      check("R3 id via 11", dout_w, 16'h0C5A);
   endtask

   task automatic t_write();
      cfg_wr(2'b00, 16'h0035);
      cfg_wr(2'b10, 16'h1234);
      cfg_rd(2'b00);
      check("R6 lp readback", dout_w, 16'h0035);
      cfg_rd(2'b10);
      check("R6 bus readback", dout_w, 16'h1234);
      cfg_wr(2'b01, 16'hBEEF);
      cfg_rd(2'b01);
      check("R4 id read-only", dout_w, 16'h0C5A);
      cfg_rd(2'b10);
      check("R4 bus untouched", dout_w, 16'h1234);
   endtask

   task automatic t_narrow();
      cfg_wr(2'b01, 16'h0077);
      cfg_rd(2'b01);
      check("R5 narrow a18 ignored", dout_n, 16'h0077);
      cfg_rd(2'b00);
      check("R5 narrow lp", dout_n, 16'h0077);
      check("R4 wide lp kept", dout_w, 16'h0035);
   endtask

   task automatic t_array();
      ce_n = 1'b0; cfg_en = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = mk(2'b00, 16'h0000);
      @(negedge clk);
      check("R2 array read strobe", {ard_w, awr_w, drv_w}, 3'b100);
      we_n = 1'b0; oe_n = 1'b1;
      @(negedge clk);
      check("R2 array write strobe", {ard_w, awr_w, drv_w}, 3'b010);
      we_n = 1'b1;
      cfg_rd(2'b00);
      check("R2 array write leaves lp", dout_w, 16'h0035);
   endtask

   task automatic t_standby();
      idle();
      check("R7 standby", st_w, 2'd0);
      cfg_rd(2'b10);
      check("R7 bus kept", dout_w, 16'h1234);
   endtask

   task automatic t_dpd();
      cfg_wr(2'b00, 16'h0025);
      idle();
      check("R8 enter dpd", st_w, 2'd2);
      ce_n = 1'b0; cfg_en = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      repeat (N-1) @(negedge clk);
      check("R9 no array write", awr_w, 1'b0);
      check("R10 short pulse", st_w, 2'd2);
      idle();
      check("R10 after short pulse", st_w, 2'd2);
      ce_n = 1'b0; cfg_en = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = mk(2'b10, 16'h0);
      repeat (N-1) @(negedge clk);
      check("R9 no cfg drive", drv_w, 1'b0);
      check("R10 still asleep", st_w, 2'd2);
      @(negedge clk);
      check("R10 wake to standby", st_w, 2'd0);
      @(negedge clk);
      check("R11 bus reloaded", dout_w, 16'h9D4F);
      cfg_rd(2'b00);
      check("R11 lp reloaded", dout_w, 16'h0010);
      idle();
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_narrow();
      t_array();
      t_standby();
      t_dpd();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule